// File: doc/BRIEF.md
# I2C Slave Pin Front End

This block sits between the two bus pins of an I2C slave and its protocol engine. Each incoming line, clock and data, first crosses into the system clock domain through two flops. It then passes a counter-based glitch filter. The system clock is assumed to run much faster than the bus. From the filtered levels the block derives the bus conditions:

- a START or repeated START, when data falls while the clock is high;
- a STOP, when data rises while the clock is high;
- a bit-sample strobe on every clock rise, carrying the data level;
- a shift strobe on every clock fall.

It also tracks whether a transfer is in progress, from START to STOP.

On the output side the engine raises a request to pull the data line low. The block turns that request into an active-high pull-low enable for an open-drain pad, so the line is never driven high. It lets the enable change only while the clock is low, and only after a hold delay that starts at the clock fall. Because of this, a transmitting slave cannot create a false START or STOP on the wire. Every output is a plain level or a one-clock pulse. There is no back-pressure: the engine must take each strobe in the cycle it appears.

The filter length and the hold delay are derived from the clock period and the nanosecond limits given as parameters:

- filter length: `FILT_CYC = SPIKE_NS/CLK_PERIOD_NS + 2`, which is 4 at the defaults;
- hold delay: `HOLD_CYC = ceil(HOLD_NS/CLK_PERIOD_NS)`, which is 15 at the defaults.

Top module: `i2c_bus_frontend`

## Requirements
- R1: While reset is asserted, and after it is released with both lines high, all pulse outputs, `sda_oe` and `bus_busy` are 0, and `scl_level`/`sda_level` are 1.
- R2: A level on either line held for fewer than FILT_CYC consecutive clock samples is ignored: the filtered level does not change and no event is produced. A level held for FILT_CYC samples or more is accepted.
- R3: An accepted change on a line shows on `scl_level`/`sda_level`, and on any event it causes, at the FILT_CYC+3rd rising clock edge, counting the first edge that samples the new level as edge 1.
- R4: SDA falling while SCL is high gives a one-clock `start_pulse`, and `bus_busy` is 1 from that same cycle.
- R5: SDA rising while SCL is high gives a one-clock `stop_pulse`, and `bus_busy` is 0 from that same cycle. START and STOP never pulse together.
- R6: A START while `bus_busy` is 1 (a repeated START) gives the same one-clock `start_pulse`, and `bus_busy` stays 1.
- R7: An SCL rise gives a one-clock `bit_valid`, with `bit_value` equal to the filtered SDA level at that rise.
- R8: An SCL fall gives a one-clock `shift_pulse`. SDA changes while SCL is low give no `start_pulse` and no `stop_pulse`.
- R9: `sda_oe` (1 = pull SDA low) takes the value of `sda_drive_req` only while `scl_level` is 0. It changes no earlier than HOLD_CYC+2 clocks after `shift_pulse`; a request already pending changes it exactly then. It holds its value while `scl_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| sda_drive_req | input | 1 | Engine request to pull SDA low |
| sda_oe | output | 1 | Open-drain pull-low enable for the SDA pad |
| scl_level | output | 1 | Filtered, registered SCL level |
| sda_level | output | 1 | Filtered, registered SDA level |
| start_pulse | output | 1 | START or repeated START seen, one clock |
| stop_pulse | output | 1 | STOP seen, one clock |
| bit_valid | output | 1 | SCL rose, one clock |
| bit_value | output | 1 | SDA level sampled at the last SCL rise |
| shift_pulse | output | 1 | SCL fell, one clock |
| bus_busy | output | 1 | Transfer in progress (between START and STOP) |

## Verification
Every pin change the bench makes lands on a falling clock edge. The latency is then exact: an event pulse appears after the FILT_CYC+3 = 7th following rising edge. The enable moves after edge 7+HOLD_CYC+2 = 24 when a request is already waiting. The scenario tasks count rising edges from each stimulus. They sample at the falling edge one cycle before the due cycle, in the due cycle and one cycle after it, so that both early and stretched pulses are caught. Glitch and ignored-change checks watch every cycle over a window longer than the full latency.

// File: rtl/i2c_fe_pkg.sv
`timescale 1ns/1ps
package i2c_fe_pkg;
  // Line indices into the two-line filter bank
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int N_LINES  = 2;

  // One-clock bus events produced by the condition detector
  typedef struct packed {
    logic start;
    logic stop;
    logic bit_valid;
    logic shift;
  } bus_evt_t;
endpackage

// File: rtl/line_filter.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a stability counter.
module line_filter #(
  parameter int FILT_CYC = 4,
  parameter bit RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          sync1, sync2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= RST_LVL;
      sync2 <= RST_LVL;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end
  end

  // Accept a new level only after FILT_CYC consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= RST_LVL;
      run_cnt <= '0;
    end else if (sync2 == level) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      level   <= sync2;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cond_detect.sv
`timescale 1ns/1ps
// Edge and bus-condition detection on the filtered lines.
module cond_detect
  import i2c_fe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_f,
  input  logic     sda_f,
  output logic     scl_q,
  output logic     sda_q,
  output bus_evt_t evt,
  output logic     bit_val,
  output logic     busy
);
  logic start_c, stop_c, rise_c, fall_c;

  always_comb begin
    start_c = scl_q & scl_f & sda_q & ~sda_f;
    stop_c  = scl_q & scl_f & ~sda_q & sda_f;
    rise_c  = ~scl_q & scl_f;
    fall_c  = scl_q & ~scl_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      evt     <= '0;
      bit_val <= 1'b0;
      busy    <= 1'b0;
    end else begin
      scl_q         <= scl_f;
      sda_q         <= sda_f;
      evt.start     <= start_c;
      evt.stop      <= stop_c;
      evt.bit_valid <= rise_c;
      evt.shift     <= fall_c;
      if (rise_c) bit_val <= sda_f;
      if (start_c)     busy <= 1'b1;
      else if (stop_c) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sda_hold.sv
`timescale 1ns/1ps
// Gates the engine's pull-low request behind a post-fall hold delay.
module sda_hold #(
  parameter int HOLD_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_low,
  input  logic shift,
  input  logic req,
  output logic oe
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);

  logic [HW-1:0] hold_cnt;
  logic          may_change;

  assign may_change = scl_low && (hold_cnt == '0) && !shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      oe       <= 1'b0;
    end else begin
      if (shift)                 hold_cnt <= LOAD;
      else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
      if (may_change)            oe <= req;
    end
  end
endmodule

// File: rtl/i2c_bus_frontend.sv
`timescale 1ns/1ps
module i2c_bus_frontend
  import i2c_fe_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int SPIKE_NS      = 50,
  parameter int HOLD_NS       = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_drive_req,
  output logic sda_oe,
  output logic scl_level,
  output logic sda_level,
  output logic start_pulse,
  output logic stop_pulse,
  output logic bit_valid,
  output logic bit_value,
  output logic shift_pulse,
  output logic bus_busy
);
  // A spike of SPIKE_NS can cover at most SPIKE_NS/period+1 samples
  localparam int FILT_CYC = SPIKE_NS / CLK_PERIOD_NS + 2;
  localparam int HOLD_CYC = (HOLD_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic [N_LINES-1:0] raw_v, filt_v;
  bus_evt_t           evt;

  assign raw_v[LINE_SCL] = scl_in;
  assign raw_v[LINE_SDA] = sda_in;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    line_filter #(.FILT_CYC(FILT_CYC), .RST_LVL(1'b1)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_v[i]),
      .level(filt_v[i])
    );
  end

  cond_detect u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f  (filt_v[LINE_SCL]),
    .sda_f  (filt_v[LINE_SDA]),
    .scl_q  (scl_level),
    .sda_q  (sda_level),
    .evt    (evt),
    .bit_val(bit_value),
    .busy   (bus_busy)
  );

  sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_low(~scl_level),
    .shift  (evt.shift),
    .req    (sda_drive_req),
    .oe     (sda_oe)
  );

  assign start_pulse = evt.start;
  assign stop_pulse  = evt.stop;
  assign bit_valid   = evt.bit_valid;
  assign shift_pulse = evt.shift;
endmodule

// File: rtl/i2c_bus_frontend_checker.sv
`timescale 1ns/1ps
module i2c_bus_frontend_checker #(
  parameter int HOLD_CYC = 15
) (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_level,
  input logic start_pulse,
  input logic stop_pulse,
  input logic bit_valid,
  input logic shift_pulse,
  input logic bus_busy
);
  localparam int SW = $clog2(HOLD_CYC + 3) + 1;
  localparam logic [SW-1:0] SMAX = '1;
  localparam logic [SW-1:0] MIN_GAP = SW'(HOLD_CYC + 1);

  // Clocks since the last shift strobe was seen, saturating
  logic [SW-1:0] since_fall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_fall <= '0;
    else if (shift_pulse)        since_fall <= '0;
    else if (since_fall != SMAX) since_fall <= since_fall + 1'b1;
  end

  a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> bus_busy);
  a_r4_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r5_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !bus_busy);
  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));
  a_r7_bit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (scl_level && !$past(scl_level)));
  a_r8_shift_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |-> !scl_level);
  a_r9_oe_frozen_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_level && $past(scl_level)) |-> (sda_oe == $past(sda_oe)));
  a_r9_oe_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (since_fall >= MIN_GAP));
endmodule

bind i2c_bus_frontend i2c_bus_frontend_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe     (sda_oe),
  .scl_level  (scl_level),
  .start_pulse(start_pulse),
  .stop_pulse (stop_pulse),
  .bit_valid  (bit_valid),
  .shift_pulse(shift_pulse),
  .bus_busy   (bus_busy)
);

// File: tb/i2c_bus_frontend_bench.sv
`timescale 1ns/1ps
module i2c_bus_frontend_bench;
  localparam int FILT   = 4;            // 50/20 + 2
  localparam int HOLD   = 15;           // ceil(300/20)
  localparam int LAT    = FILT + 3;     // edges to an event (R3)
  localparam int OE_LAT = LAT + HOLD + 2; // edges from SCL drive to oe (R9)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, sda_drive_req = 1'b0;
  logic sda_oe, scl_level, sda_level, start_pulse, stop_pulse;
  logic bit_valid, bit_value, shift_pulse, bus_busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  i2c_bus_frontend u_i2c_bus_frontend (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_drive_req(sda_drive_req), .sda_oe(sda_oe),
    .scl_level(scl_level), .sda_level(sda_level),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .bit_valid(bit_valid), .bit_value(bit_value),
    .shift_pulse(shift_pulse), .bus_busy(bus_busy)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic pick(int which);
    case (which)
      0: return start_pulse;
      1: return stop_pulse;
      2: return bit_valid;
      default: return shift_pulse;
    endcase
  endfunction

  // Drive both lines at a falling edge
  task automatic drive(logic scl, logic sda);
    @(negedge clk);
    scl_in = scl;
    sda_in = sda;
  endtask

  // After a drive: event due at edge LAT, absent one before and one after
  task automatic expect_event(string req, int which);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk); chk(req, "early", pick(which), 1'b0);
    @(negedge clk); chk(req, "due",   pick(which), 1'b1);
    @(negedge clk); chk(req, "after", pick(which), 1'b0);
  endtask

  // Drive, then require no START/STOP for a window beyond the latency
  task automatic drive_quiet(string req, logic scl, logic sda);
    int seen;
    drive(scl, sda);
    seen = 0;
    for (int i = 0; i < LAT + 6; i++) begin
      @(negedge clk);
      if (start_pulse || stop_pulse) seen++;
    end
    chk(req, "no start/stop", seen, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "oe in reset", sda_oe, 1'b0);
    chk("R1", "levels in reset", {scl_level, sda_level}, 2'b11);
    rst_n = 1'b1;
    repeat (LAT + 3) @(negedge clk);
    chk("R1", "pulses idle", {start_pulse, stop_pulse, bit_valid, shift_pulse}, 4'b0);
    chk("R1", "busy idle", bus_busy, 1'b0);
    chk("R1", "oe idle", sda_oe, 1'b0);
  endtask

  task automatic t_glitch;
    int ev, lvl;
    // SDA low for FILT-1 samples while SCL high
    drive(1'b1, 1'b0);
    repeat (FILT - 1) @(negedge clk);
    sda_in = 1'b1;
    ev = 0; lvl = 0;
    for (int i = 0; i < LAT + 8; i++) begin
      @(negedge clk);
      if (start_pulse || stop_pulse) ev++;
      if (!sda_level) lvl++;
    end
    chk("R2", "sda spike events", ev, 0);
    chk("R2", "sda spike level", lvl, 0);
    // SCL low for FILT-1 samples
    drive(1'b0, 1'b1);
    repeat (FILT - 1) @(negedge clk);
    scl_in = 1'b1;
    ev = 0; lvl = 0;
    for (int i = 0; i < LAT + 8; i++) begin
      @(negedge clk);
      if (shift_pulse || bit_valid) ev++;
      if (!scl_level) lvl++;
    end
    chk("R2", "scl spike events", ev, 0);
    chk("R2", "scl spike level", lvl, 0);
  endtask

  // SDA low for exactly FILT samples: accepted, gives START then STOP
  task automatic t_boundary;
    int st_at, sp_at;
    drive(1'b1, 1'b0);
    st_at = 0; sp_at = 0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == FILT) sda_in = 1'b1;
      if (start_pulse) begin
        st_at = i;
        chk("R4", "busy with start", bus_busy, 1'b1);
      end
      if (stop_pulse) begin
        sp_at = i;
        chk("R5", "idle with stop", bus_busy, 1'b0);
      end
    end
    chk("R3", "start edge", st_at, LAT);
    chk("R2", "stop edge after minimum hold", sp_at, LAT + FILT);
  endtask

  task automatic t_start;
    drive(1'b1, 1'b0);
    expect_event("R4", 0);
    chk("R4", "busy held", bus_busy, 1'b1);
    chk("R3", "sda level", sda_level, 1'b0);
  endtask

  task automatic t_bits;
    drive(1'b0, 1'b0);
    expect_event("R8", 3);
    drive_quiet("R8", 1'b0, 1'b1);       // SDA rises while SCL low
    drive(1'b1, 1'b1);
    expect_event("R7", 2);
    chk("R7", "bit one", bit_value, 1'b1);
    drive(1'b0, 1'b1);
    expect_event("R8", 3);
    drive_quiet("R8", 1'b0, 1'b0);       // SDA falls while SCL low
    drive(1'b1, 1'b0);
    expect_event("R7", 2);
    chk("R7", "bit zero", bit_value, 1'b0);
  endtask

  task automatic t_restart;
    drive(1'b0, 1'b0);
    repeat (LAT + 3) @(negedge clk);
    drive(1'b0, 1'b1);
    repeat (LAT + 3) @(negedge clk);
    drive(1'b1, 1'b1);
    repeat (LAT + 3) @(negedge clk);
    chk("R6", "busy before", bus_busy, 1'b1);
    drive(1'b1, 1'b0);
    expect_event("R6", 0);
    chk("R6", "busy kept", bus_busy, 1'b1);
  endtask

  task automatic t_oe;
    int moved;
    sda_drive_req = 1'b1;               // pending while SCL high
    repeat (LAT + 3) @(negedge clk);
    chk("R9", "held while high", sda_oe, 1'b0);
    drive(1'b0, 1'b0);
    repeat (OE_LAT - 1) @(posedge clk);
    @(negedge clk); chk("R9", "before hold", sda_oe, 1'b0);
    @(negedge clk); chk("R9", "after hold", sda_oe, 1'b1);
    // Past the hold, SCL low: follows next edge
    sda_drive_req = 1'b0;
    @(negedge clk); chk("R9", "follow low", sda_oe, 1'b0);
    sda_drive_req = 1'b1;
    @(negedge clk); chk("R9", "follow high", sda_oe, 1'b1);
    drive(1'b1, 1'b0);
    repeat (LAT + 3) @(negedge clk);
    sda_drive_req = 1'b0;
    moved = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sda_oe !== 1'b1) moved++;
    end
    chk("R9", "frozen while high", moved, 0);
    drive(1'b0, 1'b0);
    repeat (OE_LAT - 1) @(posedge clk);
    @(negedge clk); chk("R9", "release before hold", sda_oe, 1'b1);
    @(negedge clk); chk("R9", "release after hold", sda_oe, 1'b0);
  endtask

  task automatic t_stop;
    drive(1'b1, 1'b0);
    repeat (LAT + 3) @(negedge clk);
    drive(1'b1, 1'b1);
    expect_event("R5", 1);
    chk("R5", "idle after stop", bus_busy, 1'b0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_boundary();
    t_start();
    t_bits();
    t_restart();
    t_oe();
    t_stop();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule